// File: doc/BRIEF.md
# Scanline Table-Driven Channel Sequencer

This block walks up to eight transfer channels once per display line and moves small units of data between memory and a fixed peripheral page, steered by tables that software places in memory. It reads the per-channel configuration (control byte, peripheral offset, table start address and bank, indirect data bank) from the channel register file that it shares with a burst transfer engine. It has its own enable mask and keeps its own per-channel progress: table pointer, header byte, indirect data pointer, a pending-transfer flag and a finished flag.

A frame-start strobe primes every enabled channel. The block loads the table pointer from the start address and reads the first header byte. In indirect mode it also reads a 16-bit data pointer. Each line-start strobe then visits the channels in ascending order. An active channel may move one unit, counts down its header, and fetches the next header from its table when the 7-bit line count runs out. A header with bit 7 set makes the channel transfer on every line of its span; otherwise the channel transfers only on the first line. All memory and peripheral traffic goes through one request/acknowledge bus master port. A one-cycle done pulse marks the end of each frame-start or line-start pass.

Top module: `hdma_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `bus_req` and `pass_done` are low. Every channel counts as finished until the next frame-start pass.
- R2: Frame-start pass, for each channel whose `en_mask` bit is set:
  - the table pointer takes the start address;
  - one header byte is read from {start bank, pointer} and the pointer advances;
  - in indirect mode (control bit 6) two more bytes are read, low then high, into the data pointer;
  - the pending flag is set, and a zero header marks the channel finished.
  A channel whose mask bit is clear is marked finished.
- R3: Passes visit channels in ascending index order and skip channels that are disabled or finished. `pass_done` pulses for one cycle in the first idle cycle after each pass, and only then.
- R4: A unit follows control bits 2:0. The byte counts are: mode 0 → 1; modes 1, 2 and 6 → 2; modes 3, 4, 5 and 7 → 4. The peripheral offsets per byte are:
  - mode 0: 0
  - mode 1: 0,1
  - modes 2 and 6: 0,0
  - modes 3 and 7: 0,0,1,1
  - mode 4: 0,1,2,3
  - mode 5: 0,1,0,1
  The peripheral address is {0x00, PERIPH_PAGE, offset register + offset}, wrapping within 8 bits. For each byte the block reads the source and then writes the destination. With control bit 7 clear the data moves memory → peripheral; with it set, peripheral → memory.
- R5: On a line pass an active channel moves one unit only when its pending flag is set. It then decrements its header and sets the pending flag to bit 7 of the new header value.
- R6: When the decremented header's low 7 bits are zero, the next header byte is read from {start bank, table pointer}, the pointer advances, and the pending flag is set.
- R7: On such a reload in indirect mode, two pointer bytes (low, high) are read. If the new header is zero, only one byte is read instead; it becomes the high byte and the low byte becomes 0x00.
- R8: Unit data lives at {start bank, table pointer} in direct mode and at {indirect bank, data pointer} in indirect mode. That pointer steps by +1, by −1 when control bit 4 is set, or not at all when control bit 3 is set, with 16-bit wrap.
- R9: A zero header read on a reload finishes the channel for the rest of the frame. Its enable bit is untouched, so the next frame-start pass restarts it.
- R10: Frame-start and line-start strobes that arrive while a pass is running are ignored; frame-start wins when both arrive together. A request holds its address, direction and write data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | One-cycle frame-start strobe |
| line_stb | input | 1 | One-cycle line-start strobe |
| en_mask | input | NUM_CH | Per-channel enable |
| ch_ctrl | input | 8*NUM_CH | Control bytes (dir 7, indirect 6, decrement 4, fixed 3, mode 2:0) |
| ch_dest | input | 8*NUM_CH | Peripheral offset registers |
| ch_start_addr | input | 16*NUM_CH | Table start addresses |
| ch_start_bank | input | 8*NUM_CH | Table and direct data banks |
| ch_ind_bank | input | 8*NUM_CH | Indirect data banks |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Write when high, read when low |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Completes the current request |
| busy | output | 1 | A pass is running |
| pass_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
A strobe starts a pass one cycle later. Each bus access finishes on the edge where the bench memory acknowledges it, one cycle after the request appears. `pass_done` is high in the first idle cycle after the last channel. The bench therefore never samples at fixed cycle offsets. It logs every acknowledged access at the clock edge, waits for the done pulse, and only then compares the log, entry by entry, against the access list that its own model built for that pass. Directed cases add exact access counts per line, checked at the same point.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

   localparam int CTRL_DIR_BIT   = 7;
   localparam int CTRL_IND_BIT   = 6;
   localparam int CTRL_DEC_BIT   = 4;
   localparam int CTRL_FIXED_BIT = 3;

   typedef enum logic [3:0] {
      S_IDLE, S_SEL, S_XRD, S_XWR, S_DEC,
      S_HDR, S_PLO, S_PHI, S_FIN, S_WB, S_NEXT
   } walk_state_t;

   typedef struct packed {
      logic [15:0] tptr;
      logic [7:0]  hdr;
      logic [15:0] iptr;
      logic        do_xfer;
      logic        fin;
   } ch_state_t;

   // bytes per unit for a 3-bit mode
   function automatic logic [2:0] unit_bytes(input logic [2:0] mode);
      case (mode)
         3'd0:                unit_bytes = 3'd1;
         3'd1, 3'd2, 3'd6:    unit_bytes = 3'd2;
         default:             unit_bytes = 3'd4;
      endcase
   endfunction

   // peripheral offset of byte idx within a unit
   function automatic logic [1:0] unit_offset(input logic [2:0] mode,
                                              input logic [1:0] idx);
      case (mode)
         3'd1, 3'd5: unit_offset = {1'b0, idx[0]};
         3'd3, 3'd7: unit_offset = {1'b0, idx[1]};
         3'd4:       unit_offset = idx;
         default:    unit_offset = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/hdma_chan_state.sv
module hdma_chan_state
   import hdma_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  ch_state_t        wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output ch_state_t        rd_data
);

   ch_state_t view [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      ch_state_t r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r.tptr    <= '0;
            r.hdr     <= '0;
            r.iptr    <= '0;
            r.do_xfer <= 1'b0;
            r.fin     <= 1'b1;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            r <= wr_data;
         end
      end
      assign view[g] = r;
   end

   assign rd_data = view[rd_idx];

endmodule

// File: rtl/hdma_xfer_map.sv
module hdma_xfer_map
   import hdma_pkg::*;
#(
   parameter logic [7:0] PERIPH_BANK = 8'h00,
   parameter logic [7:0] PERIPH_PAGE = 8'h21
) (
   input  logic [2:0]  mode,
   input  logic [7:0]  dest,
   input  logic [1:0]  byte_idx,
   output logic [2:0]  unit_len,
   output logic [23:0] periph_addr
);

   logic [7:0] low;

   always_comb begin
      unit_len    = unit_bytes(mode);
      low         = dest + {6'd0, unit_offset(mode, byte_idx)};
      periph_addr = {PERIPH_BANK, PERIPH_PAGE, low};
   end

endmodule

// File: rtl/hdma_walker.sv
module hdma_walker
   import hdma_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              line_stb,
   input  logic [NUM_CH-1:0] en_mask,
   input  logic [7:0]        sel_ctrl,
   input  logic [15:0]       sel_start_addr,
   input  logic [7:0]        sel_start_bank,
   input  logic [7:0]        sel_ind_bank,
   input  logic [2:0]        unit_len,
   input  logic [23:0]       periph_addr,
   output logic [IDX_W-1:0]  ch_idx,
   output logic [1:0]        byte_idx,
   input  ch_state_t         st_rd,
   output logic              st_wr_en,
   output ch_state_t         st_wr,
   output logic              bus_req,
   output logic              bus_we,
   output logic [23:0]       bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic [7:0]        bus_rdata,
   input  logic              bus_ack,
   output logic              busy,
   output logic              pass_done
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

   walk_state_t state;
   ch_state_t   cur;
   logic        init_q;
   logic        done_q;
   logic [1:0]  k;
   logic [7:0]  byte_q;

   logic        dir, ind;
   logic [15:0] step;
   logic [7:0]  hdr_dec;
   logic [23:0] tbl_addr, data_addr;

   assign dir       = sel_ctrl[CTRL_DIR_BIT];
   assign ind       = sel_ctrl[CTRL_IND_BIT];
   assign step      = sel_ctrl[CTRL_FIXED_BIT] ? 16'h0000 :
                      sel_ctrl[CTRL_DEC_BIT]   ? 16'hFFFF : 16'h0001;
   assign hdr_dec   = cur.hdr - 8'd1;
   assign tbl_addr  = {sel_start_bank, cur.tptr};
   assign data_addr = ind ? {sel_ind_bank, cur.iptr} : {sel_start_bank, cur.tptr};

   assign byte_idx  = k;
   assign busy      = (state != S_IDLE);
   assign pass_done = done_q;

   // state write-back: whole channel at the end of its visit, or a
   // finished mark for a channel left out of the frame-start pass
   always_comb begin
      st_wr_en = 1'b0;
      st_wr    = cur;
      if (state == S_WB) begin
         st_wr_en = 1'b1;
      end else if (state == S_SEL && init_q && !en_mask[ch_idx]) begin
         st_wr_en      = 1'b1;
         st_wr         = st_rd;
         st_wr.do_xfer = 1'b0;
         st_wr.fin     = 1'b1;
      end
   end

   // bus master outputs, held stable while in a bus state
   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = tbl_addr;
      bus_wdata = byte_q;
      case (state)
         S_XRD: begin
            bus_req  = 1'b1;
            bus_addr = dir ? periph_addr : data_addr;
         end
         S_XWR: begin
            bus_req  = 1'b1;
            bus_we   = 1'b1;
            bus_addr = dir ? data_addr : periph_addr;
         end
         S_HDR, S_PLO, S_PHI: bus_req = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cur    <= '0;
         init_q <= 1'b0;
         done_q <= 1'b0;
         k      <= '0;
         byte_q <= '0;
         ch_idx <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            S_IDLE: begin
               if (frame_stb) begin
                  init_q <= 1'b1;
                  ch_idx <= '0;
                  state  <= S_SEL;
               end else if (line_stb) begin
                  init_q <= 1'b0;
                  ch_idx <= '0;
                  state  <= S_SEL;
               end
            end
            S_SEL: begin
               k <= '0;
               if (init_q) begin
                  if (en_mask[ch_idx]) begin
                     cur.tptr    <= sel_start_addr;
                     cur.hdr     <= '0;
                     cur.iptr    <= st_rd.iptr;
                     cur.do_xfer <= 1'b0;
                     cur.fin     <= 1'b0;
                     state       <= S_HDR;
                  end else begin
                     state <= S_NEXT;
                  end
               end else if (en_mask[ch_idx] && !st_rd.fin) begin
                  cur   <= st_rd;
                  state <= st_rd.do_xfer ? S_XRD : S_DEC;
               end else begin
                  state <= S_NEXT;
               end
            end
            S_XRD: begin
               if (bus_ack) begin
                  byte_q <= bus_rdata;
                  state  <= S_XWR;
               end
            end
            S_XWR: begin
               if (bus_ack) begin
                  if (ind) cur.iptr <= cur.iptr + step;
                  else     cur.tptr <= cur.tptr + step;
                  if ({1'b0, k} == unit_len - 3'd1) begin
                     state <= S_DEC;
                  end else begin
                     k     <= k + 2'd1;
                     state <= S_XRD;
                  end
               end
            end
            S_DEC: begin
               cur.hdr     <= hdr_dec;
               cur.do_xfer <= hdr_dec[7];
               state       <= (hdr_dec[6:0] == 7'd0) ? S_HDR : S_WB;
            end
            S_HDR: begin
               if (bus_ack) begin
                  cur.hdr  <= bus_rdata;
                  cur.tptr <= cur.tptr + 16'd1;
                  if (!ind) begin
                     state <= S_FIN;
                  end else if (init_q || bus_rdata != 8'd0) begin
                     state <= S_PLO;
                  end else begin
                     cur.iptr[7:0] <= 8'd0;
                     state         <= S_PHI;
                  end
               end
            end
            S_PLO: begin
               if (bus_ack) begin
                  cur.iptr[7:0] <= bus_rdata;
                  cur.tptr      <= cur.tptr + 16'd1;
                  state         <= S_PHI;
               end
            end
            S_PHI: begin
               if (bus_ack) begin
                  cur.iptr[15:8] <= bus_rdata;
                  cur.tptr       <= cur.tptr + 16'd1;
                  state          <= S_FIN;
               end
            end
            S_FIN: begin
               cur.fin     <= (cur.hdr == 8'd0);
               cur.do_xfer <= 1'b1;
               state       <= S_WB;
            end
            S_WB: state <= S_NEXT;
            S_NEXT: begin
               if (ch_idx == LAST) begin
                  done_q <= 1'b1;
                  state  <= S_IDLE;
               end else begin
                  ch_idx <= ch_idx + 1'b1;
                  state  <= S_SEL;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hdma_seq.sv
module hdma_seq
   import hdma_pkg::*;
#(
   parameter int         NUM_CH      = 8,
   parameter logic [7:0] PERIPH_BANK = 8'h00,
   parameter logic [7:0] PERIPH_PAGE = 8'h21
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_stb,
   input  logic                 line_stb,
   input  logic [NUM_CH-1:0]    en_mask,
   input  logic [8*NUM_CH-1:0]  ch_ctrl,
   input  logic [8*NUM_CH-1:0]  ch_dest,
   input  logic [16*NUM_CH-1:0] ch_start_addr,
   input  logic [8*NUM_CH-1:0]  ch_start_bank,
   input  logic [8*NUM_CH-1:0]  ch_ind_bank,
   output logic                 bus_req,
   output logic                 bus_we,
   output logic [23:0]          bus_addr,
   output logic [7:0]           bus_wdata,
   input  logic [7:0]           bus_rdata,
   input  logic                 bus_ack,
   output logic                 busy,
   output logic                 pass_done
);

   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_count
      $error("hdma_seq: NUM_CH must lie in 1..16");
   end

   logic [IDX_W-1:0] ch_idx;
   logic [1:0]       byte_idx;
   logic [7:0]       sel_ctrl, sel_dest, sel_start_bank, sel_ind_bank;
   logic [15:0]      sel_start_addr;
   logic [2:0]       unit_len;
   logic [23:0]      periph_addr;
   ch_state_t        st_rd, st_wr;
   logic             st_wr_en;

   assign sel_ctrl       = ch_ctrl      [ch_idx*8  +: 8];
   assign sel_dest       = ch_dest      [ch_idx*8  +: 8];
   assign sel_start_bank = ch_start_bank[ch_idx*8  +: 8];
   assign sel_ind_bank   = ch_ind_bank  [ch_idx*8  +: 8];
   assign sel_start_addr = ch_start_addr[ch_idx*16 +: 16];

   hdma_chan_state #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st_wr_en),
      .wr_idx  (ch_idx),
      .wr_data (st_wr),
      .rd_idx  (ch_idx),
      .rd_data (st_rd)
   );

   hdma_xfer_map #(.PERIPH_BANK(PERIPH_BANK), .PERIPH_PAGE(PERIPH_PAGE)) u_map (
      .mode        (sel_ctrl[2:0]),
      .dest        (sel_dest),
      .byte_idx    (byte_idx),
      .unit_len    (unit_len),
      .periph_addr (periph_addr)
   );

   hdma_walker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_walk (
      .clk            (clk),
      .rst_n          (rst_n),
      .frame_stb      (frame_stb),
      .line_stb       (line_stb),
      .en_mask        (en_mask),
      .sel_ctrl       (sel_ctrl),
      .sel_start_addr (sel_start_addr),
      .sel_start_bank (sel_start_bank),
      .sel_ind_bank   (sel_ind_bank),
      .unit_len       (unit_len),
      .periph_addr    (periph_addr),
      .ch_idx         (ch_idx),
      .byte_idx       (byte_idx),
      .st_rd          (st_rd),
      .st_wr_en       (st_wr_en),
      .st_wr          (st_wr),
      .bus_req        (bus_req),
      .bus_we         (bus_we),
      .bus_addr       (bus_addr),
      .bus_wdata      (bus_wdata),
      .bus_rdata      (bus_rdata),
      .bus_ack        (bus_ack),
      .busy           (busy),
      .pass_done      (pass_done)
   );

endmodule

// File: rtl/hdma_seq_chk.sv
module hdma_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_req,
   input logic        bus_ack,
   input logic        bus_we,
   input logic [23:0] bus_addr,
   input logic [7:0]  bus_wdata,
   input logic        busy,
   input logic        pass_done
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req) else $error("idle with request");                // R1

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                              && $stable(bus_wdata)) else $error("request dropped"); // R10

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done) else $error("done longer than one cycle");  // R3

   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> pass_done) else $error("pass ended without done");    // R3

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |-> !busy) else $error("done while busy");                  // R3

endmodule

bind hdma_seq hdma_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_ack   (bus_ack),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .busy      (busy),
   .pass_done (pass_done)
);

// File: tb/test_hdma_seq.sv
module test_hdma_seq;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        frame_stb = 1'b0, line_stb = 1'b0;
   logic [7:0]  en_mask = '0;
   logic [63:0] ch_ctrl = '0, ch_dest = '0, ch_start_bank = '0, ch_ind_bank = '0;
   logic [127:0] ch_start_addr = '0;
   logic        bus_req, bus_we, busy, pass_done;
   logic [23:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata = '0;
   logic        bus_ack = 1'b0;

   hdma_seq i_hdma_seq (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .line_stb(line_stb),
      .en_mask(en_mask), .ch_ctrl(ch_ctrl), .ch_dest(ch_dest),
      .ch_start_addr(ch_start_addr), .ch_start_bank(ch_start_bank),
      .ch_ind_bank(ch_ind_bank), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .busy(busy), .pass_done(pass_done)
   );

   int n_chk = 0, n_fail = 0, done_cnt = 0, cyc = 0;

   // ---------------- memories: bench bus slave and model copy
   logic [7:0] bmem [logic [23:0]];
   logic [7:0] rmem [logic [23:0]];

   function automatic logic [7:0] dflt(input logic [23:0] a);
      return a[7:0] ^ (a[15:8] * 8'd3) ^ (a[23:16] * 8'd5) ^ 8'h5A;
   endfunction
   function automatic logic [7:0] rd_b(input logic [23:0] a);
      return bmem.exists(a) ? bmem[a] : dflt(a);
   endfunction
   function automatic logic [7:0] rd_r(input logic [23:0] a);
      return rmem.exists(a) ? rmem[a] : dflt(a);
   endfunction
   task automatic put(input logic [23:0] a, input logic [7:0] v);
      bmem[a] = v;
      rmem[a] = v;
   endtask

   logic [32:0] obs_q[$];
   logic [32:0] exp_q[$];
   string       tag_q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         bus_ack <= 1'b0;
      end else begin
         if (bus_req && bus_ack)
            obs_q.push_back({bus_we, bus_addr, bus_we ? bus_wdata : bus_rdata});
         if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) bmem[bus_addr] = bus_wdata;
            else        bus_rdata <= rd_b(bus_addr);
         end else begin
            bus_ack <= 1'b0;
         end
      end
      if (rst_n && pass_done) done_cnt++;
   end

   // ---------------- checking
   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- reference model
   logic [7:0]  c_ctrl[8], c_dest[8], c_sbank[8], c_ibank[8];
   logic [15:0] c_saddr[8];
   logic        c_en[8];
   logic [15:0] m_tptr[8], m_iptr[8];
   logic [7:0]  m_hdr[8];
   logic        m_do[8], m_fin[8];

   task automatic apply_cfg();
      @(negedge clk);
      for (int c = 0; c < 8; c++) begin
         en_mask[c]               = c_en[c];
         ch_ctrl[c*8 +: 8]        = c_ctrl[c];
         ch_dest[c*8 +: 8]        = c_dest[c];
         ch_start_bank[c*8 +: 8]  = c_sbank[c];
         ch_ind_bank[c*8 +: 8]    = c_ibank[c];
         ch_start_addr[c*16 +: 16] = c_saddr[c];
      end
   endtask

   task automatic m_rd(input logic [23:0] a, input string tag, output logic [7:0] v);
      v = rd_r(a);
      exp_q.push_back({1'b0, a, v});
      tag_q.push_back(tag);
   endtask
   task automatic m_wr(input logic [23:0] a, input logic [7:0] v, input string tag);
      rmem[a] = v;
      exp_q.push_back({1'b1, a, v});
      tag_q.push_back(tag);
   endtask

   function automatic int m_len(input logic [2:0] m);
      if (m == 0) return 1;
      if (m == 1 || m == 2 || m == 6) return 2;
      return 4;
   endfunction
   function automatic logic [7:0] m_off(input logic [2:0] m, input int i);
      int t4[4];
      case (m)
         3'd1, 3'd5: t4 = '{0, 1, 0, 1};
         3'd3, 3'd7: t4 = '{0, 0, 1, 1};
         3'd4:       t4 = '{0, 1, 2, 3};
         default:    t4 = '{0, 0, 0, 0};
      endcase
      return 8'(t4[i]);
   endfunction

   task automatic m_ptrs(input int c, input bit single_hi);
      logic [7:0] lo, hi;
      lo = 8'h00;
      if (!single_hi) begin
         m_rd({c_sbank[c], m_tptr[c]}, "R7", lo);
         m_tptr[c]++;
      end
      m_rd({c_sbank[c], m_tptr[c]}, "R7", hi);
      m_tptr[c]++;
      m_iptr[c] = {hi, lo};
   endtask

   task automatic ref_init();
      logic [7:0] v;
      for (int c = 0; c < 8; c++) begin
         if (c_en[c]) begin
            m_tptr[c] = c_saddr[c];
            m_rd({c_sbank[c], m_tptr[c]}, "R2", v);
            m_hdr[c] = v;
            m_tptr[c]++;
            if (c_ctrl[c][6]) begin
               m_rd({c_sbank[c], m_tptr[c]}, "R2", v); m_iptr[c][7:0]  = v; m_tptr[c]++;
               m_rd({c_sbank[c], m_tptr[c]}, "R2", v); m_iptr[c][15:8] = v; m_tptr[c]++;
            end
            m_fin[c] = (m_hdr[c] == 0);
            m_do[c]  = 1'b1;
         end else begin
            m_fin[c] = 1'b1;
            m_do[c]  = 1'b0;
         end
      end
   endtask

   task automatic ref_line();
      logic [7:0]  v;
      logic [23:0] pa, da;
      logic [15:0] st;
      for (int c = 0; c < 8; c++) begin
         if (!c_en[c] || m_fin[c]) continue;
         st = c_ctrl[c][3] ? 16'h0 : (c_ctrl[c][4] ? 16'hFFFF : 16'h1);
         if (m_do[c]) begin
            for (int i = 0; i < m_len(c_ctrl[c][2:0]); i++) begin
               pa = {8'h00, 8'h21, c_dest[c] + m_off(c_ctrl[c][2:0], i)};
               da = c_ctrl[c][6] ? {c_ibank[c], m_iptr[c]} : {c_sbank[c], m_tptr[c]};
               if (c_ctrl[c][7]) begin m_rd(pa, "R4", v); m_wr(da, v, "R8"); end
               else              begin m_rd(da, "R8", v); m_wr(pa, v, "R4"); end
               if (c_ctrl[c][6]) m_iptr[c] += st; else m_tptr[c] += st;
            end
         end
         m_hdr[c]--;
         m_do[c] = m_hdr[c][7];
         if (m_hdr[c][6:0] == 0) begin
            m_rd({c_sbank[c], m_tptr[c]}, "R6", v);
            m_hdr[c] = v;
            m_tptr[c]++;
            if (c_ctrl[c][6]) m_ptrs(c, v == 0);
            m_fin[c] = (v == 0);
            m_do[c]  = 1'b1;
         end
      end
   endtask

   // ---------------- stimulus helpers
   task automatic wait_done(input int d0);
      for (int i = 0; i < 20000 && done_cnt == d0; i++) @(negedge clk);
   endtask

   task automatic pass(input bit frame, input string what);
      int d0, n;
      if (frame) ref_init(); else ref_line();
      obs_q.delete();
      @(negedge clk);
      d0 = done_cnt;
      if (frame) frame_stb = 1'b1; else line_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0; line_stb = 1'b0;
      wait_done(d0);
      @(negedge clk);
      check(done_cnt == d0 + 1, "R3", {what, " done pulses"}, 64'(done_cnt - d0), 64'd1);
      check(obs_q.size() == exp_q.size(), "R3", {what, " access count"},
            64'(obs_q.size()), 64'(exp_q.size()));
      n = (obs_q.size() < exp_q.size()) ? obs_q.size() : exp_q.size();
      for (int i = 0; i < n; i++)
         check(obs_q[i] == exp_q[i], tag_q[i], {what, " access"}, 64'(obs_q[i]), 64'(exp_q[i]));
      exp_q.delete();
      tag_q.delete();
   endtask

   task automatic clear_cfg();
      for (int c = 0; c < 8; c++) begin
         c_en[c] = 0; c_ctrl[c] = 0; c_dest[c] = 0;
         c_sbank[c] = 8'(c + 1); c_ibank[c] = 8'(8'h40 + c); c_saddr[c] = 16'(c * 16'h0400);
      end
   endtask

   function automatic logic [7:0] rnd_hdr();
      if ($urandom % 14 == 0) return 8'h00;
      return {1'($urandom), 5'd0, 2'(($urandom % 3) + 1)};
   endfunction

   initial begin
      int d0;
      void'($urandom(32'd1234));
      for (int c = 0; c < 8; c++) m_fin[c] = 1'b1;
      clear_cfg();
      apply_cfg();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !bus_req && !pass_done, "R1", "reset outputs",
            {busy, bus_req, pass_done}, 3'b000);

      // line before any frame start: all channels finished
      c_en = '{default: 1'b1};
      apply_cfg();
      pass(1'b0, "R1 line before frame start");

      // R10: second strobe during a pass is ignored
      c_en = '{default: 1'b0};
      apply_cfg();
      obs_q.delete();
      d0 = done_cnt;
      @(negedge clk); line_stb = 1'b1;
      @(negedge clk); line_stb = 1'b0;
      @(negedge clk); line_stb = 1'b1; frame_stb = 1'b1;
      @(negedge clk); line_stb = 1'b0; frame_stb = 1'b0;
      wait_done(d0);
      repeat (40) @(negedge clk);
      check(done_cnt == d0 + 1, "R10", "strobes while busy", 64'(done_cnt - d0), 64'd1);
      check(obs_q.size() == 0, "R10", "no access with all disabled", 64'(obs_q.size()), 64'd0);

      // R2/R5/R6 direct channel 1, mode 0
      clear_cfg();
      c_en[1] = 1; c_sbank[1] = 8'h02; c_saddr[1] = 16'h2000; c_dest[1] = 8'h10;
      put(24'h022000, 8'h03); put(24'h022001, 8'h55); put(24'h022002, 8'h82);
      put(24'h022005, 8'h00);
      apply_cfg();
      pass(1'b1, "R2 direct frame start");
      check(obs_q.size() == 1 && obs_q[0][31:8] == 24'h022000, "R2", "first header address",
            64'(obs_q[0][31:8]), 64'h022000);
      begin
         int want[5] = '{2, 0, 1, 2, 3};
         for (int l = 0; l < 5; l++) begin
            pass(1'b0, "R5 direct line");
            check(obs_q.size() == want[l], "R5", "accesses per line", 64'(obs_q.size()), 64'(want[l]));
         end
      end
      pass(1'b0, "R9 after end");
      check(obs_q.size() == 0, "R9", "finished channel quiet", 64'(obs_q.size()), 64'd0);

      // R7 indirect reload with zero header
      clear_cfg();
      c_en[0] = 1; c_ctrl[0] = 8'h40; c_sbank[0] = 8'h01; c_saddr[0] = 16'h1000; c_ibank[0] = 8'h7E;
      put(24'h011000, 8'h01); put(24'h011001, 8'h34); put(24'h011002, 8'h12);
      put(24'h011003, 8'h00); put(24'h011004, 8'hAB);
      apply_cfg();
      pass(1'b1, "R2 indirect frame start");
      pass(1'b0, "R7 zero-header reload");
      check(obs_q.size() == 4, "R7", "single pointer byte", 64'(obs_q.size()), 64'd4);
      check(obs_q[0][31:8] == 24'h7E1234, "R8", "indirect data address", 64'(obs_q[0][31:8]), 64'h7E1234);
      check(obs_q[3][31:8] == 24'h011004, "R7", "pointer byte address", 64'(obs_q[3][31:8]), 64'h011004);
      pass(1'b0, "R9 finished indirect");
      check(obs_q.size() == 0, "R9", "no traffic after end", 64'(obs_q.size()), 64'd0);
      pass(1'b1, "R9 restart");
      check(obs_q.size() == 3, "R9", "restart at frame start", 64'(obs_q.size()), 64'd3);

      // random frames: R4 R6 R7 R8 against the model
      for (int f = 0; f < 6; f++) begin
         for (int c = 0; c < 8; c++) begin
            c_en[c]    = 1'($urandom);
            c_ctrl[c]  = 8'($urandom) & 8'hDF;
            c_dest[c]  = 8'($urandom);
            c_sbank[c] = 8'(8'h10 + c);
            c_ibank[c] = 8'(8'h50 + c);
            c_saddr[c] = 16'($urandom) | 16'h0080;
            for (int b = -8; b < 96; b++)
               put({c_sbank[c], 16'(c_saddr[c] + 16'(b))}, rnd_hdr());
         end
         apply_cfg();
         pass(1'b1, "R2 random frame start");
         for (int l = 0; l < 10; l++) pass(1'b0, "R4 R6 R8 random line");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule